// File: doc/BRIEF.md
# Bus Watch Comparator

This block watches one of two bus masters and checks each valid bus cycle of the chosen master against values held in configuration inputs. When a cycle qualifies, it raises a single-cycle match pulse. Downstream logic can use that pulse as an event source, for example for trace or debug sequencing.

Three address modes are available:
- **Exact mode** compares the address against a reference. The data-capable variant can also compare the data bus, restricted to the bits selected by a per-bit mask.
- **Inside mode** hits when the address lies within an inclusive window.
- **Outside mode** hits when the address lies outside that window.

Each match can also be restricted by transfer direction and by access size. Each of these two restrictions has its own enable.

The block is fully synchronous. The match output is a register: a bus cycle presented on one clock edge produces its pulse after that edge and holds it until the next edge. The `HAS_DATA` parameter removes the data compare for address-only instances.

Top module: `bus_watch_cmp`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `match_o` is 0.
- R2: In exact mode (`cfg_mode` = 0), the watched address must equal `cfg_addr_lo`. When this holds together with every other enabled condition, `match_o` is 1 in the clock cycle following the sampled bus cycle.
- R3: In exact mode with `cfg_data_en` = 1, bit i of the data bus must equal bit i of `cfg_data_ref` for every i where `cfg_data_mask[i]` = 1. Bits whose mask bit is 0 have no effect. When `cfg_data_en` = 0, the data bus has no effect.
- R4: In inside mode (`cfg_mode` = 1), the address hits when `cfg_addr_lo` ≤ address ≤ `cfg_addr_hi`, with both bounds inclusive.
- R5: In outside mode (`cfg_mode` = 2), the address hits when address < `cfg_addr_lo` or address > `cfg_addr_hi`.
- R6: When `cfg_master_sel` = 0, master 0 is watched; when it is 1, master 1 is watched. The signals of the unwatched master have no effect on `match_o`.
- R7: When `cfg_rnw_en` = 1, a match also requires the watched master's `rnw` to equal `cfg_rnw_val`, where 1 means read. When `cfg_rnw_en` = 0, direction has no effect.
- R8: When `cfg_size_en` = 1, a match also requires the watched master's `word` to equal `cfg_size_val`, where 1 means a word access and 0 a byte access. When `cfg_size_en` = 0, size has no effect.
- R9: A match requires the watched master's `valid` to be 1. Each qualifying cycle gives exactly one cycle of `match_o`, and back-to-back qualifying cycles keep `match_o` high.
- R10: When `cfg_en` = 0, or when `cfg_mode` = 3, `match_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m0_valid | input | 1 | Master 0 bus cycle valid |
| m0_addr | input | ADDR_W | Master 0 address |
| m0_data | input | DATA_W | Master 0 data |
| m0_rnw | input | 1 | Master 0 direction, 1 = read |
| m0_word | input | 1 | Master 0 size, 1 = word |
| m1_valid | input | 1 | Master 1 bus cycle valid |
| m1_addr | input | ADDR_W | Master 1 address |
| m1_data | input | DATA_W | Master 1 data |
| m1_rnw | input | 1 | Master 1 direction, 1 = read |
| m1_word | input | 1 | Master 1 size, 1 = word |
| cfg_en | input | 1 | Comparator enable |
| cfg_mode | input | 2 | 0 exact, 1 inside, 2 outside, 3 off |
| cfg_master_sel | input | 1 | Watched master |
| cfg_addr_lo | input | ADDR_W | Exact reference / lower bound |
| cfg_addr_hi | input | ADDR_W | Upper bound |
| cfg_data_en | input | 1 | Enable data compare in exact mode |
| cfg_data_ref | input | DATA_W | Data reference |
| cfg_data_mask | input | DATA_W | 1 = bit takes part in compare |
| cfg_rnw_en | input | 1 | Enable direction qualifier |
| cfg_rnw_val | input | 1 | Required direction |
| cfg_size_en | input | 1 | Enable size qualifier |
| cfg_size_val | input | 1 | Required size |
| match_o | output | 1 | Registered match pulse |

## Verification
The hardest situation to reach from the ports is one where every condition passes at once: the selected master is valid, direction and size both agree, and the address sits exactly on a window bound or the data differs from the reference only in masked-out bits. Uniformly random values almost never produce this combination.

To get there, the random stimulus builds addresses from the current bounds: lo−1, lo, hi, hi+1, or an interior point. It builds data from the reference with bits flipped only under mask zeros, and it sets the qualifiers to the required values most of the time.

Directed vectors then cover the remaining corners:
- a window of a single address;
- bounds programmed in reverse order;
- a busy unwatched master;
- the off mode.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
   typedef enum logic [1:0] {
      BWC_EXACT   = 2'd0,
      BWC_INSIDE  = 2'd1,
      BWC_OUTSIDE = 2'd2,
      BWC_OFF     = 2'd3
   } bwc_mode_e;

   typedef struct packed {
      logic rnw;
      logic word;
   } bwc_attr_t;
endpackage

// File: rtl/bwc_master_mux.sv
module bwc_master_mux #(
   parameter int AW = 23,
   parameter int DW = 16
) (
   input  logic          sel,
   input  logic          a_valid,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_data,
   input  bwc_pkg::bwc_attr_t a_attr,
   input  logic          b_valid,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_data,
   input  bwc_pkg::bwc_attr_t b_attr,
   output logic          o_valid,
   output logic [AW-1:0] o_addr,
   output logic [DW-1:0] o_data,
   output bwc_pkg::bwc_attr_t o_attr
);
   always_comb begin
      if (sel) begin
         o_valid = b_valid;
         o_addr  = b_addr;
         o_data  = b_data;
         o_attr  = b_attr;
      end else begin
         o_valid = a_valid;
         o_addr  = a_addr;
         o_data  = a_data;
         o_attr  = a_attr;
      end
   end
endmodule

// File: rtl/bwc_addr_cmp.sv
module bwc_addr_cmp #(
   parameter int AW = 23
) (
   input  bwc_pkg::bwc_mode_e mode,
   input  logic [AW-1:0]      addr,
   input  logic [AW-1:0]      lo,
   input  logic [AW-1:0]      hi,
   output logic               hit,
   output logic               exact
);
   logic at_lo, ge_lo, le_hi;

   assign at_lo = (addr == lo);
   assign ge_lo = (addr >= lo);
   assign le_hi = (addr <= hi);

   always_comb begin
      exact = 1'b0;
      unique case (mode)
         bwc_pkg::BWC_EXACT: begin
            hit   = at_lo;
            exact = 1'b1;
         end
         bwc_pkg::BWC_INSIDE:  hit = ge_lo & le_hi;
         bwc_pkg::BWC_OUTSIDE: hit = ~ge_lo | ~le_hi;
         default:              hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/bwc_data_cmp.sv
module bwc_data_cmp #(
   parameter int DW       = 16,
   parameter bit HAS_DATA = 1'b1
) (
   input  logic          en,
   input  logic [DW-1:0] data,
   input  logic [DW-1:0] ref_val,
   input  logic [DW-1:0] mask,
   output logic          hit
);
   generate
      if (HAS_DATA) begin : g_data
         logic [DW-1:0] miss;
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign miss[i] = mask[i] & (data[i] ^ ref_val[i]);
         end
         assign hit = ~en | ~(|miss);
      end else begin : g_nodata
         logic unused;
         assign unused = en ^ (^data) ^ (^ref_val) ^ (^mask);
         assign hit    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bwc_attr_qual.sv
module bwc_attr_qual (
   input  bwc_pkg::bwc_attr_t attr,
   input  logic               rnw_en,
   input  logic               rnw_val,
   input  logic               size_en,
   input  logic               size_val,
   output logic               ok
);
   logic rnw_ok, size_ok;

   assign rnw_ok  = ~rnw_en  | (attr.rnw  == rnw_val);
   assign size_ok = ~size_en | (attr.word == size_val);
   assign ok      = rnw_ok & size_ok;
endmodule

// File: rtl/bus_watch_cmp.sv
module bus_watch_cmp #(
   parameter int ADDR_W   = 23,
   parameter int DATA_W   = 16,
   parameter bit HAS_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              m0_valid,
   input  logic [ADDR_W-1:0] m0_addr,
   input  logic [DATA_W-1:0] m0_data,
   input  logic              m0_rnw,
   input  logic              m0_word,
   input  logic              m1_valid,
   input  logic [ADDR_W-1:0] m1_addr,
   input  logic [DATA_W-1:0] m1_data,
   input  logic              m1_rnw,
   input  logic              m1_word,
   input  logic              cfg_en,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_master_sel,
   input  logic [ADDR_W-1:0] cfg_addr_lo,
   input  logic [ADDR_W-1:0] cfg_addr_hi,
   input  logic              cfg_data_en,
   input  logic [DATA_W-1:0] cfg_data_ref,
   input  logic [DATA_W-1:0] cfg_data_mask,
   input  logic              cfg_rnw_en,
   input  logic              cfg_rnw_val,
   input  logic              cfg_size_en,
   input  logic              cfg_size_val,
   output logic              match_o
);
   import bwc_pkg::*;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("bus_watch_cmp: ADDR_W must be 2..32");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
         $error("bus_watch_cmp: DATA_W must be 1..64");
      end
   endgenerate

   bwc_attr_t        m0_attr, m1_attr, sel_attr;
   logic             sel_valid;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_data;
   bwc_mode_e        mode;
   logic             addr_hit, is_exact, data_hit, attr_ok, hit_now;

   assign m0_attr = '{rnw: m0_rnw, word: m0_word};
   assign m1_attr = '{rnw: m1_rnw, word: m1_word};
   assign mode    = bwc_mode_e'(cfg_mode);

   bwc_master_mux #(.AW(ADDR_W), .DW(DATA_W)) u_mux (
      .sel     (cfg_master_sel),
      .a_valid (m0_valid), .a_addr (m0_addr), .a_data (m0_data), .a_attr (m0_attr),
      .b_valid (m1_valid), .b_addr (m1_addr), .b_data (m1_data), .b_attr (m1_attr),
      .o_valid (sel_valid), .o_addr (sel_addr), .o_data (sel_data), .o_attr (sel_attr)
   );

   bwc_addr_cmp #(.AW(ADDR_W)) u_addr (
      .mode  (mode),
      .addr  (sel_addr),
      .lo    (cfg_addr_lo),
      .hi    (cfg_addr_hi),
      .hit   (addr_hit),
      .exact (is_exact)
   );

   bwc_data_cmp #(.DW(DATA_W), .HAS_DATA(HAS_DATA)) u_data (
      .en      (cfg_data_en & is_exact),
      .data    (sel_data),
      .ref_val (cfg_data_ref),
      .mask    (cfg_data_mask),
      .hit     (data_hit)
   );

   bwc_attr_qual u_qual (
      .attr     (sel_attr),
      .rnw_en   (cfg_rnw_en),
      .rnw_val  (cfg_rnw_val),
      .size_en  (cfg_size_en),
      .size_val (cfg_size_val),
      .ok       (attr_ok)
   );

   assign hit_now = cfg_en & sel_valid & addr_hit & data_hit & attr_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) match_o <= 1'b0;
      else        match_o <= hit_now;
   end
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker #(
   parameter int AW = 23
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_en,
   input logic [1:0]    cfg_mode,
   input logic          cfg_master_sel,
   input logic          m0_valid,
   input logic [AW-1:0] m0_addr,
   input logic          m0_rnw,
   input logic          m0_word,
   input logic          m1_valid,
   input logic [AW-1:0] m1_addr,
   input logic          m1_rnw,
   input logic          m1_word,
   input logic [AW-1:0] cfg_addr_lo,
   input logic [AW-1:0] cfg_addr_hi,
   input logic          cfg_rnw_en,
   input logic          cfg_rnw_val,
   input logic          cfg_size_en,
   input logic          cfg_size_val,
   input logic          match_o
);
   logic          w_valid, w_rnw, w_word;
   logic [AW-1:0] w_addr;
   logic          rst_seen;

   assign w_valid = cfg_master_sel ? m1_valid : m0_valid;
   assign w_addr  = cfg_master_sel ? m1_addr  : m0_addr;
   assign w_rnw   = cfg_master_sel ? m1_rnw   : m0_rnw;
   assign w_word  = cfg_master_sel ? m1_word  : m0_word;

   always_ff @(posedge clk) rst_seen <= ~rst_n;

   AST_RESET_QUIET: assert property (@(posedge clk) rst_seen |-> !match_o); // R1
   AST_EXACT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd0 && w_addr != cfg_addr_lo) |=> !match_o); // R2
   AST_INSIDE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd1 && (w_addr < cfg_addr_lo || w_addr > cfg_addr_hi)) |=> !match_o); // R4
   AST_OUTSIDE_MID: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'd2 && w_addr >= cfg_addr_lo && w_addr <= cfg_addr_hi) |=> !match_o); // R5
   AST_RNW_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rnw_en && w_rnw != cfg_rnw_val) |=> !match_o); // R7
   AST_SIZE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_size_en && w_word != cfg_size_val) |=> !match_o); // R8
   AST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !w_valid |=> !match_o); // R9
   AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en || cfg_mode == 2'd3) |=> !match_o); // R10
endmodule

bind bus_watch_cmp bwc_checker #(.AW(ADDR_W)) u_bwc_checker (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
   .cfg_master_sel(cfg_master_sel),
   .m0_valid(m0_valid), .m0_addr(m0_addr), .m0_rnw(m0_rnw), .m0_word(m0_word),
   .m1_valid(m1_valid), .m1_addr(m1_addr), .m1_rnw(m1_rnw), .m1_word(m1_word),
   .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
   .cfg_rnw_en(cfg_rnw_en), .cfg_rnw_val(cfg_rnw_val),
   .cfg_size_en(cfg_size_en), .cfg_size_val(cfg_size_val),
   .match_o(match_o)
);

// File: tb/bus_watch_cmp_test.sv
module bus_watch_cmp_test;
   localparam int AW = 23;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          m0_valid, m0_rnw, m0_word, m1_valid, m1_rnw, m1_word;
   logic [AW-1:0] m0_addr, m1_addr, cfg_addr_lo, cfg_addr_hi;
   logic [DW-1:0] m0_data, m1_data, cfg_data_ref, cfg_data_mask;
   logic          cfg_en, cfg_master_sel, cfg_data_en;
   logic [1:0]    cfg_mode;
   logic          cfg_rnw_en, cfg_rnw_val, cfg_size_en, cfg_size_val;
   logic          match_o;

   int  vectors = 0;
   int  fails   = 0;
   bit  done    = 0;

   always #10 clk = ~clk;   // 50 MHz

   bus_watch_cmp #(.ADDR_W(AW), .DATA_W(DW), .HAS_DATA(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .m0_valid(m0_valid), .m0_addr(m0_addr), .m0_data(m0_data), .m0_rnw(m0_rnw), .m0_word(m0_word),
      .m1_valid(m1_valid), .m1_addr(m1_addr), .m1_data(m1_data), .m1_rnw(m1_rnw), .m1_word(m1_word),
      .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_master_sel(cfg_master_sel),
      .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
      .cfg_data_en(cfg_data_en), .cfg_data_ref(cfg_data_ref), .cfg_data_mask(cfg_data_mask),
      .cfg_rnw_en(cfg_rnw_en), .cfg_rnw_val(cfg_rnw_val),
      .cfg_size_en(cfg_size_en), .cfg_size_val(cfg_size_val),
      .match_o(match_o)
   );

   // Expected result from the requirements
   function automatic bit expect_match();
      bit          v, r, w, ah, dh;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      v = cfg_master_sel ? m1_valid : m0_valid;   // R6
      a = cfg_master_sel ? m1_addr  : m0_addr;
      d = cfg_master_sel ? m1_data  : m0_data;
      r = cfg_master_sel ? m1_rnw   : m0_rnw;
      w = cfg_master_sel ? m1_word  : m0_word;
      dh = 1'b1;
      case (cfg_mode)
         2'd0: begin
            ah = (a == cfg_addr_lo);
            if (cfg_data_en) dh = (((d ^ cfg_data_ref) & cfg_data_mask) == '0);
         end
         2'd1: ah = (a >= cfg_addr_lo) && (a <= cfg_addr_hi);
         2'd2: ah = (a < cfg_addr_lo) || (a > cfg_addr_hi);
         default: ah = 1'b0;
      endcase
      if (cfg_rnw_en  && r != cfg_rnw_val)  return 1'b0;
      if (cfg_size_en && w != cfg_size_val) return 1'b0;
      return cfg_en && v && ah && dh;
   endfunction

   // Inputs are set at a falling edge; the next falling edge sees the registered result
   task automatic apply(input string req);
      bit e;
      e = expect_match();
      @(negedge clk);
      vectors++;
      if (match_o !== e) begin
         fails++;
         $display("FAIL %s: match_o=%b expected %b (mode=%0d sel=%0d)", req, match_o, e, cfg_mode, cfg_master_sel);
      end
   endtask

   task automatic quiet_cfg();
      cfg_en = 1; cfg_mode = 2'd0; cfg_master_sel = 0;
      cfg_addr_lo = 23'h001000; cfg_addr_hi = 23'h001FFF;
      cfg_data_en = 0; cfg_data_ref = '0; cfg_data_mask = '1;
      cfg_rnw_en = 0; cfg_rnw_val = 0; cfg_size_en = 0; cfg_size_val = 0;
      m0_valid = 0; m0_addr = '0; m0_data = '0; m0_rnw = 0; m0_word = 0;
      m1_valid = 0; m1_addr = '0; m1_data = '0; m1_rnw = 0; m1_word = 0;
   endtask

   task automatic set_watched(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit r, input bit w);
      if (cfg_master_sel) begin
         m1_valid = 1; m1_addr = a; m1_data = d; m1_rnw = r; m1_word = w;
      end else begin
         m0_valid = 1; m0_addr = a; m0_data = d; m0_rnw = r; m0_word = w;
      end
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0B5C);
      rst_n = 0;
      quiet_cfg();
      m0_valid = 1; m0_addr = 23'h001000;
      repeat (3) @(negedge clk);
      vectors++;
      if (match_o !== 1'b0) begin fails++; $display("FAIL R1: match_o=%b expected 0 in reset", match_o); end
      rst_n = 1;
      vectors++;
      if (match_o !== 1'b0) begin fails++; $display("FAIL R1: match_o=%b expected 0 after reset", match_o); end

      // R2 exact hit, then neighbour miss
      quiet_cfg(); set_watched(23'h001000, 16'h0, 0, 0); apply("R2");
      set_watched(23'h001001, 16'h0, 0, 0); apply("R2");
      // R3 masked data: differs only under mask zeros -> hit; differs under a one -> miss
      cfg_data_en = 1; cfg_data_ref = 16'hA5A5; cfg_data_mask = 16'hFF00;
      set_watched(23'h001000, 16'hA5FF, 0, 0); apply("R3");
      set_watched(23'h001000, 16'hA4A5, 0, 0); apply("R3");
      cfg_data_en = 0; apply("R3");
      // R4 inclusive window, single-address window
      quiet_cfg(); cfg_mode = 2'd1;
      set_watched(23'h000FFF, '0, 0, 0); apply("R4");
      set_watched(23'h001000, '0, 0, 0); apply("R4");
      set_watched(23'h001FFF, '0, 0, 0); apply("R4");
      set_watched(23'h002000, '0, 0, 0); apply("R4");
      cfg_addr_hi = 23'h001000; set_watched(23'h001000, '0, 0, 0); apply("R4");
      cfg_addr_lo = 23'h002000; apply("R4");   // reversed bounds: no hit
      // R5 outside
      quiet_cfg(); cfg_mode = 2'd2;
      set_watched(23'h000FFF, '0, 0, 0); apply("R5");
      set_watched(23'h001000, '0, 0, 0); apply("R5");
      set_watched(23'h002000, '0, 0, 0); apply("R5");
      // R6 master select: busy unwatched master ignored
      quiet_cfg(); cfg_master_sel = 1;
      m0_valid = 1; m0_addr = 23'h001000; apply("R6");
      set_watched(23'h001000, '0, 0, 0); m0_addr = 23'h7FFFFF; apply("R6");
      // R7 direction qualifier
      cfg_rnw_en = 1; cfg_rnw_val = 1; apply("R7");
      m1_rnw = 1; apply("R7");
      // R8 size qualifier
      cfg_size_en = 1; cfg_size_val = 1; apply("R8");
      m1_word = 1; apply("R8");
      // R9 back-to-back stays high, then valid low drops it
      apply("R9"); apply("R9");
      m1_valid = 0; apply("R9");
      // R10 disable and off mode
      m1_valid = 1; cfg_en = 0; apply("R10");
      cfg_en = 1; cfg_mode = 2'd3; apply("R10");

      // Constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [AW-1:0] base, a;
         logic [DW-1:0] d;
         int pick;
         base = AW'($urandom);
         cfg_en = ($urandom % 16) != 0;
         cfg_mode = 2'($urandom % 4);
         cfg_master_sel = 1'($urandom);
         cfg_addr_lo = base;
         cfg_addr_hi = (($urandom % 8) == 0) ? AW'($urandom) : base + AW'($urandom % 64);
         cfg_data_en = 1'($urandom); cfg_data_ref = DW'($urandom); cfg_data_mask = DW'($urandom);
         cfg_rnw_en = 1'($urandom); cfg_rnw_val = 1'($urandom);
         cfg_size_en = 1'($urandom); cfg_size_val = 1'($urandom);
         pick = $urandom % 6;
         case (pick)
            0: a = cfg_addr_lo - 1'b1;
            1: a = cfg_addr_lo;
            2: a = cfg_addr_hi;
            3: a = cfg_addr_hi + 1'b1;
            4: a = cfg_addr_lo + AW'($urandom % 32);
            default: a = AW'($urandom);
         endcase
         d = (($urandom % 4) != 0) ? (cfg_data_ref ^ (DW'($urandom) & ~cfg_data_mask)) : DW'($urandom);
         m0_valid = 1'($urandom); m0_addr = AW'($urandom); m0_data = DW'($urandom);
         m0_rnw = 1'($urandom); m0_word = 1'($urandom);
         m1_valid = 1'($urandom); m1_addr = AW'($urandom); m1_data = DW'($urandom);
         m1_rnw = 1'($urandom); m1_word = 1'($urandom);
         set_watched(a, d,
                     (($urandom % 4) != 0) ? cfg_rnw_val : 1'($urandom),
                     (($urandom % 4) != 0) ? cfg_size_val : 1'($urandom));
         if (($urandom % 8) == 0) begin
            if (cfg_master_sel) m1_valid = 0; else m0_valid = 0;
         end
         apply("R2-R10 random");
      end

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule